// File: doc/BRIEF.md
# Word-Framed Receive FIFO

This block is a circular receive store for variable-length frames built from 32-bit words. A producer writes one word per cycle. The first word of each frame is a header, and a frame-start strobe carries the frame's total length in words with that header. The block decides at the start strobe whether the whole frame fits into the free space. A frame that fits is stored word by word. A frame that does not fit is discarded as a unit, and an overrun condition is recorded.

A consumer drains the store through a single read strobe, one word per strobe. The block treats the first word popped of every frame as its header and decodes the header's word-count field, so it always knows where the current frame ends. From this it keeps a count of complete frames held. It reports read and write positions, capacity and free space in words, empty and full flags, a sticky overrun flag with one-cycle overrun and receive event pulses, and a wrapping count of received frames. Three command inputs flush the store, clear the overrun flag and clear the received-frame count.

Top module: `word_rx_fifo`

## Requirements
- R1: A frame of L words (1 ≤ L ≤ MAX_FRAME_WORDS), presented with wr_start and wr_valid on its header word, is accepted only if the fill plus L does not exceed DEPTH_WORDS at that cycle. The fill never exceeds DEPTH_WORDS.
- R2: A frame that does not fit is dropped whole. In the cycle after its start, overrun_flag is 1 and overrun_evt pulses for one cycle. The free space, the write pointer and frame_count are unchanged by the frame's words.
- R3: In the cycle after an accepted frame's last word is stored, rx_evt pulses for one cycle, and frame_count and rx_frame_ctr have each risen by one.
- R4: A rd_en strobe while frame_count is non-zero pops the oldest stored word. In the next cycle rd_data holds that word, rd_ptr has advanced by one modulo DEPTH_WORDS, and free_words has grown by one. Word order is kept across the wrap.
- R5: The first word popped of each frame is its header. Bits [15:11] (HDR_CNT_LSB=11, HDR_CNT_W=5) hold the frame's word count minus one. frame_count decreases by one when that frame's last word is popped.
- R6: A rd_en strobe while frame_count is 0 returns 0 on rd_data in the next cycle and changes no pointer, count or flag.
- R7: wr_ptr equals (rd_ptr + fill) modulo DEPTH_WORDS. free_words equals DEPTH_WORDS minus the fill. capacity_words equals DEPTH_WORDS.
- R8: rx_empty is 1 exactly when frame_count is 0. rx_full is 1 exactly when the fill equals DEPTH_WORDS.
- R9: A cmd_flush strobe zeroes both pointers, the fill, frame_count and the frame in progress on both sides in the next cycle.
- R10: A cmd_clr_overrun strobe clears overrun_flag. A new overrun in the same cycle takes priority.
- R11: A cmd_clr_rx_ctr strobe zeroes rx_frame_ctr. It takes priority over a frame completing in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_start | input | 1 | Frame start, marks the header word |
| wr_len | input | LEN_W | Frame length in words, valid with wr_start |
| wr_valid | input | 1 | Write word valid |
| wr_data | input | WORD_W | Write word |
| rd_en | input | 1 | Pop one word |
| rd_data | output | WORD_W | Word popped by the previous strobe |
| cmd_flush | input | 1 | Empty the store |
| cmd_clr_overrun | input | 1 | Clear the overrun flag |
| cmd_clr_rx_ctr | input | 1 | Clear the received-frame count |
| rd_ptr | output | PTR_W | Read position |
| wr_ptr | output | PTR_W | Write position |
| capacity_words | output | FILL_W | Store size in words |
| free_words | output | FILL_W | Free space in words |
| frame_count | output | FILL_W | Complete frames stored |
| rx_empty | output | 1 | No complete frame stored |
| rx_full | output | 1 | Store completely filled |
| overrun_flag | output | 1 | Sticky overrun status |
| overrun_evt | output | 1 | One-cycle overrun event |
| rx_evt | output | 1 | One-cycle frame received event |
| rx_frame_ctr | output | CTR_W | Wrapping count of accepted frames |

## Verification
The bench builds the block with DEPTH_WORDS=24 and MAX_FRAME_WORDS=20. Because 24 is not a power of two, the explicit pointer wrap variant is exercised. The small store also means that two 12-word frames fill it exactly, so a full store, a rejected frame at the exact capacity boundary and frequent wrap-around during random traffic all happen within a few hundred operations. Random frame lengths up to 20 words against a 24-word store give a high rate of rejections mixed with successful admissions.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
   typedef enum logic [0:0] {
      WS_IDLE = 1'b0,
      WS_BUSY = 1'b1
   } wr_state_e;

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/rxf_ptr_step.sv
module rxf_ptr_step #(
   parameter int DEPTH = 64,
   parameter int PTR_W = 6
) (
   input  logic [PTR_W-1:0] cur,
   output logic [PTR_W-1:0] nxt
);
   localparam bit POW2 = rxf_pkg::is_pow2(DEPTH);
   localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

   generate
      if (POW2) begin : g_natural
         assign nxt = cur + PTR_W'(1);
      end else begin : g_compare
         assign nxt = (cur == LAST) ? '0 : cur + PTR_W'(1);
      end
   endgenerate
endmodule

// File: rtl/rxf_store.sv
module rxf_store #(
   parameter int DEPTH  = 64,
   parameter int WORD_W = 32,
   parameter int PTR_W  = 6
) (
   input  logic              clk,
   input  logic              we,
   input  logic [PTR_W-1:0]  waddr,
   input  logic [WORD_W-1:0] wdata,
   input  logic [PTR_W-1:0]  raddr,
   output logic [WORD_W-1:0] rdata
);
   logic [WORD_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];
endmodule

// File: rtl/rxf_wr_ctl.sv
module rxf_wr_ctl #(
   parameter int DEPTH     = 64,
   parameter int MAX_FRAME = 20,
   parameter int PTR_W     = 6,
   parameter int FILL_W    = 7,
   parameter int LEN_W     = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              wr_start,
   input  logic              wr_valid,
   input  logic [LEN_W-1:0]  wr_len,
   input  logic [FILL_W-1:0] fill,
   output logic              mem_we,
   output logic [PTR_W-1:0]  wr_ptr,
   output logic              commit,
   output logic              reject
);
   import rxf_pkg::*;

   localparam int SUM_W = ((FILL_W > LEN_W) ? FILL_W : LEN_W) + 1;
   localparam logic [SUM_W-1:0] CAP_S = SUM_W'(DEPTH);
   localparam logic [LEN_W-1:0] MAX_L = LEN_W'(MAX_FRAME);
   localparam logic [LEN_W-1:0] ONE_L = LEN_W'(1);

   wr_state_e        state_q;
   logic [LEN_W-1:0] left_q;
   logic [PTR_W-1:0] ptr_q;
   logic [PTR_W-1:0] ptr_nxt;
   logic [SUM_W-1:0] need;
   logic             fits;
   logic             len_ok;
   logic             start_ok;
   logic             cont;

   rxf_ptr_step #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_step (
      .cur (ptr_q),
      .nxt (ptr_nxt)
   );

   always_comb begin
      need     = SUM_W'(fill) + SUM_W'(wr_len);
      fits     = need <= CAP_S;
      len_ok   = (wr_len != '0) && (wr_len <= MAX_L);
      start_ok = wr_start && wr_valid && (state_q == WS_IDLE) && len_ok && fits;
      reject   = wr_start && wr_valid && !start_ok;
      cont     = wr_valid && !wr_start && (state_q == WS_BUSY);
      mem_we   = start_ok || cont;
      commit   = (start_ok && (wr_len == ONE_L)) || (cont && (left_q == ONE_L));
   end

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         state_q <= WS_IDLE;
         left_q  <= '0;
         ptr_q   <= '0;
      end else begin
         if (mem_we) ptr_q <= ptr_nxt;
         if (start_ok) begin
            left_q  <= wr_len - ONE_L;
            state_q <= (wr_len == ONE_L) ? WS_IDLE : WS_BUSY;
         end else if (cont) begin
            left_q <= left_q - ONE_L;
            if (left_q == ONE_L) state_q <= WS_IDLE;
         end
      end
   end

   assign wr_ptr = ptr_q;
endmodule

// File: rtl/rxf_rd_ctl.sv
module rxf_rd_ctl #(
   parameter int DEPTH       = 64,
   parameter int WORD_W      = 32,
   parameter int PTR_W       = 6,
   parameter int FILL_W      = 7,
   parameter int HDR_CNT_LSB = 11,
   parameter int HDR_CNT_W   = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              rd_en,
   input  logic [FILL_W-1:0] frames,
   input  logic [WORD_W-1:0] mem_rdata,
   output logic [PTR_W-1:0]  rd_ptr,
   output logic              pop,
   output logic              frame_done,
   output logic [WORD_W-1:0] rd_data
);
   localparam logic [HDR_CNT_W-1:0] ONE_R = HDR_CNT_W'(1);

   logic [PTR_W-1:0]     ptr_q;
   logic [PTR_W-1:0]     ptr_nxt;
   logic [HDR_CNT_W-1:0] rem_q;
   logic [HDR_CNT_W-1:0] hdr_cnt;
   logic                 in_frame;
   logic [WORD_W-1:0]    data_q;

   rxf_ptr_step #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_step (
      .cur (ptr_q),
      .nxt (ptr_nxt)
   );

   always_comb begin
      hdr_cnt    = mem_rdata[HDR_CNT_LSB +: HDR_CNT_W];
      in_frame   = rem_q != '0;
      pop        = rd_en && (frames != '0);
      frame_done = pop && (in_frame ? (rem_q == ONE_R) : (hdr_cnt == '0));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr_q  <= '0;
         rem_q  <= '0;
         data_q <= '0;
      end else if (flush) begin
         ptr_q <= '0;
         rem_q <= '0;
      end else if (pop) begin
         data_q <= mem_rdata;
         ptr_q  <= ptr_nxt;
         rem_q  <= in_frame ? rem_q - ONE_R : hdr_cnt;
      end else if (rd_en) begin
         data_q <= '0;
      end
   end

   assign rd_ptr  = ptr_q;
   assign rd_data = data_q;
endmodule

// File: rtl/word_rx_fifo.sv
module word_rx_fifo #(
   parameter int DEPTH_WORDS     = 64,
   parameter int WORD_W          = 32,
   parameter int MAX_FRAME_WORDS = 20,
   parameter int HDR_CNT_LSB     = 11,
   parameter int HDR_CNT_W       = 5,
   parameter int CTR_W           = 16,
   localparam int PTR_W  = $clog2(DEPTH_WORDS),
   localparam int FILL_W = $clog2(DEPTH_WORDS + 1),
   localparam int LEN_W  = $clog2(MAX_FRAME_WORDS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_start,
   input  logic [LEN_W-1:0]  wr_len,
   input  logic              wr_valid,
   input  logic [WORD_W-1:0] wr_data,
   input  logic              rd_en,
   output logic [WORD_W-1:0] rd_data,
   input  logic              cmd_flush,
   input  logic              cmd_clr_overrun,
   input  logic              cmd_clr_rx_ctr,
   output logic [PTR_W-1:0]  rd_ptr,
   output logic [PTR_W-1:0]  wr_ptr,
   output logic [FILL_W-1:0] capacity_words,
   output logic [FILL_W-1:0] free_words,
   output logic [FILL_W-1:0] frame_count,
   output logic              rx_empty,
   output logic              rx_full,
   output logic              overrun_flag,
   output logic              overrun_evt,
   output logic              rx_evt,
   output logic [CTR_W-1:0]  rx_frame_ctr
);
   localparam logic [FILL_W-1:0] CAP = FILL_W'(DEPTH_WORDS);

   initial begin
      assert (DEPTH_WORDS >= 2) else $error("DEPTH_WORDS must be at least 2");
      assert (MAX_FRAME_WORDS >= 1 && MAX_FRAME_WORDS <= DEPTH_WORDS)
         else $error("MAX_FRAME_WORDS must lie in 1..DEPTH_WORDS");
      assert ((1 << HDR_CNT_W) >= MAX_FRAME_WORDS)
         else $error("header count field too narrow for MAX_FRAME_WORDS");
      assert (HDR_CNT_LSB + HDR_CNT_W <= WORD_W)
         else $error("header count field outside the word");
      assert (CTR_W >= 1) else $error("CTR_W must be positive");
   end

   logic [FILL_W-1:0] fill;
   logic [FILL_W-1:0] frames_q;
   logic              mem_we;
   logic              commit;
   logic              reject;
   logic              pop;
   logic              frame_done;
   logic [WORD_W-1:0] mem_rdata;
   logic              ovr_q;
   logic              ovr_evt_q;
   logic              rx_evt_q;
   logic [CTR_W-1:0]  ctr_q;

   rxf_wr_ctl #(
      .DEPTH(DEPTH_WORDS), .MAX_FRAME(MAX_FRAME_WORDS),
      .PTR_W(PTR_W), .FILL_W(FILL_W), .LEN_W(LEN_W)
   ) u_wr (
      .clk      (clk),
      .rst_n    (rst_n),
      .flush    (cmd_flush),
      .wr_start (wr_start),
      .wr_valid (wr_valid),
      .wr_len   (wr_len),
      .fill     (fill),
      .mem_we   (mem_we),
      .wr_ptr   (wr_ptr),
      .commit   (commit),
      .reject   (reject)
   );

   rxf_store #(.DEPTH(DEPTH_WORDS), .WORD_W(WORD_W), .PTR_W(PTR_W)) u_store (
      .clk   (clk),
      .we    (mem_we),
      .waddr (wr_ptr),
      .wdata (wr_data),
      .raddr (rd_ptr),
      .rdata (mem_rdata)
   );

   rxf_rd_ctl #(
      .DEPTH(DEPTH_WORDS), .WORD_W(WORD_W), .PTR_W(PTR_W), .FILL_W(FILL_W),
      .HDR_CNT_LSB(HDR_CNT_LSB), .HDR_CNT_W(HDR_CNT_W)
   ) u_rd (
      .clk        (clk),
      .rst_n      (rst_n),
      .flush      (cmd_flush),
      .rd_en      (rd_en),
      .frames     (frames_q),
      .mem_rdata  (mem_rdata),
      .rd_ptr     (rd_ptr),
      .pop        (pop),
      .frame_done (frame_done),
      .rd_data    (rd_data)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fill      <= '0;
         frames_q  <= '0;
         ovr_q     <= 1'b0;
         ovr_evt_q <= 1'b0;
         rx_evt_q  <= 1'b0;
         ctr_q     <= '0;
      end else begin
         if (cmd_flush) begin
            fill     <= '0;
            frames_q <= '0;
         end else begin
            fill     <= fill + FILL_W'(mem_we) - FILL_W'(pop);
            frames_q <= frames_q + FILL_W'(commit) - FILL_W'(frame_done);
         end
         if (reject)               ovr_q <= 1'b1;
         else if (cmd_clr_overrun) ovr_q <= 1'b0;
         ovr_evt_q <= reject;
         rx_evt_q  <= commit && !cmd_flush;
         if (cmd_clr_rx_ctr)              ctr_q <= '0;
         else if (commit && !cmd_flush)   ctr_q <= ctr_q + CTR_W'(1);
      end
   end

   assign capacity_words = CAP;
   assign free_words     = CAP - fill;
   assign frame_count    = frames_q;
   assign rx_empty       = frames_q == '0;
   assign rx_full        = fill == CAP;
   assign overrun_flag   = ovr_q;
   assign overrun_evt    = ovr_evt_q;
   assign rx_evt         = rx_evt_q;
   assign rx_frame_ctr   = ctr_q;
endmodule

// File: rtl/word_rx_fifo_chk.sv
module word_rx_fifo_chk #(
   parameter int DEPTH_WORDS = 64,
   parameter int WORD_W      = 32,
   parameter int PTR_W       = 6,
   parameter int FILL_W      = 7
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rd_en,
   input logic              cmd_flush,
   input logic              rx_empty,
   input logic [WORD_W-1:0] rd_data,
   input logic [PTR_W-1:0]  rd_ptr,
   input logic [PTR_W-1:0]  wr_ptr,
   input logic [FILL_W-1:0] fill,
   input logic [FILL_W-1:0] frame_count,
   input logic              overrun_evt,
   input logic              overrun_flag,
   input logic              rx_evt
);
   // R1: the fill stays within the store
   assert_no_overflow_R1: assert property (@(posedge clk) disable iff (!rst_n)
      int'(fill) <= DEPTH_WORDS);

   // R2: an overrun event always comes with the sticky flag
   assert_overrun_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
      overrun_evt |-> overrun_flag);

   // R3: a receive event means at least the new frame is held
   assert_rx_event_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rx_evt |-> (frame_count != '0));

   // R4: a pop with frames held moves the read pointer
   assert_pop_moves_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !rx_empty && !cmd_flush) |=> (rd_ptr != $past(rd_ptr)));

   // R6: an empty read yields zero and leaves the pointer
   assert_empty_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && rx_empty && !cmd_flush) |=> ((rd_data == '0) && $stable(rd_ptr)));

   // R7: write position follows read position plus fill
   assert_wptr_relation_R7: assert property (@(posedge clk) disable iff (!rst_n)
      int'(wr_ptr) == ((int'(rd_ptr) + int'(fill)) % DEPTH_WORDS));

   // R9: a flush leaves an empty store
   assert_flush_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_flush |=> ((fill == '0) && (frame_count == '0) && (rd_ptr == '0) && (wr_ptr == '0)));
endmodule

bind word_rx_fifo word_rx_fifo_chk #(
   .DEPTH_WORDS(DEPTH_WORDS), .WORD_W(WORD_W), .PTR_W(PTR_W), .FILL_W(FILL_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .rd_en        (rd_en),
   .cmd_flush    (cmd_flush),
   .rx_empty     (rx_empty),
   .rd_data      (rd_data),
   .rd_ptr       (rd_ptr),
   .wr_ptr       (wr_ptr),
   .fill         (fill),
   .frame_count  (frame_count),
   .overrun_evt  (overrun_evt),
   .overrun_flag (overrun_flag),
   .rx_evt       (rx_evt)
);

// File: tb/word_rx_fifo_tb.sv
`timescale 1ns/1ps
module word_rx_fifo_tb;
   localparam int DEPTH  = 24;
   localparam int MAXF   = 20;
   localparam int PTR_W  = $clog2(DEPTH);
   localparam int FILL_W = $clog2(DEPTH + 1);
   localparam int LEN_W  = $clog2(MAXF + 1);

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              wr_start = 1'b0;
   logic [LEN_W-1:0]  wr_len = '0;
   logic              wr_valid = 1'b0;
   logic [31:0]       wr_data = '0;
   logic              rd_en = 1'b0;
   logic [31:0]       rd_data;
   logic              cmd_flush = 1'b0;
   logic              cmd_clr_overrun = 1'b0;
   logic              cmd_clr_rx_ctr = 1'b0;
   logic [PTR_W-1:0]  rd_ptr;
   logic [PTR_W-1:0]  wr_ptr;
   logic [FILL_W-1:0] capacity_words;
   logic [FILL_W-1:0] free_words;
   logic [FILL_W-1:0] frame_count;
   logic              rx_empty;
   logic              rx_full;
   logic              overrun_flag;
   logic              overrun_evt;
   logic              rx_evt;
   logic [15:0]       rx_frame_ctr;

   always #2.5 clk = ~clk;

   word_rx_fifo #(
      .DEPTH_WORDS(DEPTH), .WORD_W(32), .MAX_FRAME_WORDS(MAXF),
      .HDR_CNT_LSB(11), .HDR_CNT_W(5), .CTR_W(16)
   ) u_dut (.*);

   int n_chk = 0;
   int n_fail = 0;

   // reference model
   int unsigned m_q[$];
   int m_frames = 0;
   int m_rem = 0;
   int m_rd = 0;
   int m_ovr = 0;
   int m_ctr = 0;

   function automatic int m_fill();
      return m_q.size();
   endfunction

   function automatic int m_wr();
      return (m_rd + m_q.size()) % DEPTH;
   endfunction

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic check_status();
      chk(free_words == FILL_W'(DEPTH - m_fill()), "R7 free_words", free_words, DEPTH - m_fill());
      chk(int'(wr_ptr) == m_wr(), "R7 wr_ptr", wr_ptr, m_wr());
      chk(int'(rd_ptr) == m_rd, "R4 rd_ptr", rd_ptr, m_rd);
      chk(int'(frame_count) == m_frames, "R5 frame_count", frame_count, m_frames);
      chk(rx_empty == (m_frames == 0), "R8 rx_empty", rx_empty, m_frames == 0);
      chk(rx_full == (m_fill() == DEPTH), "R8 rx_full", rx_full, m_fill() == DEPTH);
      chk(int'(overrun_flag) == m_ovr, "R10 overrun_flag", overrun_flag, m_ovr);
      chk(int'(rx_frame_ctr) == m_ctr, "R11 rx_frame_ctr", rx_frame_ctr, m_ctr);
   endtask

   task automatic write_frame(input int len);
      int unsigned w[$];
      bit acc;
      int unsigned hdr;
      hdr = $urandom;
      hdr[15:11] = 5'(len - 1);
      w.push_back(hdr);
      for (int i = 1; i < len; i++) w.push_back($urandom);
      acc = (m_fill() + len) <= DEPTH;
      @(negedge clk);
      wr_valid = 1'b1; wr_start = 1'b1; wr_len = LEN_W'(len); wr_data = w[0];
      for (int i = 1; i < len; i++) begin
         @(negedge clk);
         if (i == 1 && !acc) chk(overrun_evt == 1'b1, "R2 overrun_evt", overrun_evt, 1);
         wr_start = 1'b0; wr_data = w[i];
      end
      @(negedge clk);
      if (len == 1 && !acc) chk(overrun_evt == 1'b1, "R2 overrun_evt", overrun_evt, 1);
      wr_valid = 1'b0; wr_start = 1'b0;
      if (acc) begin
         foreach (w[i]) m_q.push_back(w[i]);
         m_frames++;
         m_ctr = (m_ctr + 1) & 16'hffff;
         chk(rx_evt == 1'b1, "R3 rx_evt", rx_evt, 1);
      end else begin
         m_ovr = 1;
         chk(rx_evt == 1'b0, "R2 no rx_evt", rx_evt, 0);
      end
      check_status();
   endtask

   task automatic read_word();
      int unsigned exp;
      @(negedge clk);
      rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
      if (m_frames == 0) begin
         exp = 0;
         chk(rd_data == exp, "R6 empty read data", rd_data, exp);
      end else begin
         exp = m_q.pop_front();
         if (m_rem == 0) m_rem = int'(exp[15:11]) + 1;
         m_rem--;
         if (m_rem == 0) m_frames--;
         m_rd = (m_rd + 1) % DEPTH;
         chk(rd_data == exp, "R4 pop data", rd_data, exp);
      end
      check_status();
   endtask

   task automatic flush();
      @(negedge clk);
      cmd_flush = 1'b1;
      @(negedge clk);
      cmd_flush = 1'b0;
      m_q.delete(); m_frames = 0; m_rem = 0; m_rd = 0;
      chk(rd_ptr == '0 && wr_ptr == '0 && frame_count == '0, "R9 flush", {rd_ptr, wr_ptr}, 0);
      check_status();
   endtask

   task automatic clr_overrun();
      @(negedge clk);
      cmd_clr_overrun = 1'b1;
      @(negedge clk);
      cmd_clr_overrun = 1'b0;
      m_ovr = 0;
      chk(overrun_flag == 1'b0, "R10 clear overrun", overrun_flag, 0);
      check_status();
   endtask

   task automatic clr_ctr();
      @(negedge clk);
      cmd_clr_rx_ctr = 1'b1;
      @(negedge clk);
      cmd_clr_rx_ctr = 1'b0;
      m_ctr = 0;
      chk(rx_frame_ctr == '0, "R11 clear counter", rx_frame_ctr, 0);
      check_status();
   endtask

   initial begin
      #(200000 * 5);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // reset state
      chk(capacity_words == FILL_W'(DEPTH), "R7 capacity", capacity_words, DEPTH);
      chk(overrun_evt == 1'b0 && rx_evt == 1'b0, "R3 no events after reset", {overrun_evt, rx_evt}, 0);
      check_status();
      // R6: read from empty store
      read_word();
      // R8: exact fill to capacity, then R2 rejection at the boundary
      write_frame(12);
      write_frame(12);
      chk(rx_full == 1'b1, "R8 full at capacity", rx_full, 1);
      write_frame(4);
      write_frame(1);
      clr_overrun();
      // R5: drain across a frame boundary
      for (int i = 0; i < 14; i++) read_word();
      // R4: wrap-around with order kept
      write_frame(8);
      write_frame(MAXF - 6);
      for (int i = 0; i < 40; i++) read_word();
      clr_ctr();
      // R9: flush with data held
      write_frame(5);
      write_frame(3);
      read_word();
      flush();
      read_word();
      // random traffic
      for (int it = 0; it < 400; it++) begin
         int r;
         r = int'($urandom_range(99));
         if (r < 42)      write_frame(int'($urandom_range(MAXF, 1)));
         else if (r < 92) read_word();
         else if (r < 95) flush();
         else if (r < 98) clr_overrun();
         else             clr_ctr();
      end
      while (m_frames != 0) read_word();
      read_word();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule